// File: doc/BRIEF.md
# Debug Unlock Gate with Two-World Challenge-Response

This block decides which debug capabilities a device exposes to an external debugger. A fuse-selected security level and the device lifecycle state set the base policy. When the level asks for authentication and the device is closed, the debugger has to unlock each privilege world. It sends a request and reads back the 64-bit device unique ID as a challenge. It then submits a 128-bit response. The block holds one response key for the non-secure world and one for the secure world. A response that equals a key unlocks that key's world only. Both worlds can be unlocked one after the other in the same session.

Before any granted enable appears, the block raises a level request to wipe sensitive data. It holds that request until an acknowledge returns. The keys are loaded one 32-bit word at a time. Writes are accepted only while the device is in the open lifecycle state. Boundary scan has its own enable, which does not depend on the debug grants.

Top module: `dbg_unlock_gate`

## Requirements
- R1: Security level encoding is 0 = off, 1 = no-debug, 2 = challenge, 3 = open. Level 3 drives both debug enables high. Levels 0 and 1 drive both low. Lifecycle 2 (no-return) overrides every level and forces both enables low.
- R2: Lifecycle encoding is 0 = open, 1 and 3 = closed, 2 = no-return. At level 2 with lifecycle 0, the non-secure enable is high and the secure enable is low, with no response needed.
- R3: The unlock sequence is active only at level 2 with a closed lifecycle. In that state, a request pulse makes `chal_vld_o` high from the next cycle, with `chal_o` equal to `uid_i`. In any other state a request is ignored. `chal_o` reads zero whenever `chal_vld_o` is low.
- R4: A response submitted while the challenge is shown is compared against both keys in the following cycle. A match on the normal key grants the non-secure world. A match on the secure key grants the secure world. Granting one world leaves the other unchanged.
- R5: A response that matches neither key grants nothing. It sets `fail_o` two cycles after submission. `fail_o` stays set until the cycle after the next accepted request.
- R6: A response submitted with no pending request, while the sequence is active, is rejected and sets `fail_o` in the next cycle.
- R7: On a match, `wipe_req_o` rises one cycle after the compare cycle. It stays high until `wipe_ack_i` is sampled high. The new grant becomes visible in the cycle after that acknowledge. No enable rises before it.
- R8: Grants persist until reset, including across later failed responses.
- R9: A key write selects the key with `key_sel_i` (0 = normal, 1 = secure) and the 32-bit word with `key_word_i` (word 0 holds bits 31:0). Writes take effect only in lifecycle 0 and are ignored in every other lifecycle.
- R10: Both keys reset to all zeros, so an all-zero response unlocks both worlds on an unprogrammed device.
- R11: `bscan_en_o` is low exactly when the level is 0 or the lifecycle is 2. It is independent of the debug grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sec_level_i | input | 2 | Fuse-selected security level |
| lifecycle_i | input | 2 | Device lifecycle state |
| uid_i | input | 64 | Device unique ID, used as the challenge |
| key_wr_i | input | 1 | Key word write strobe |
| key_sel_i | input | 1 | Key select: 0 normal, 1 secure |
| key_word_i | input | 2 | Word index within the selected key |
| key_data_i | input | 32 | Key word write data |
| req_i | input | 1 | Unlock request pulse |
| chal_o | output | 64 | Challenge value |
| chal_vld_o | output | 1 | Challenge valid, waiting for a response |
| resp_vld_i | input | 1 | Response valid strobe |
| resp_i | input | 128 | Submitted response |
| wipe_req_o | output | 1 | Sensitive-data wipe request (level) |
| wipe_ack_i | input | 1 | Wipe acknowledge |
| ns_dbg_en_o | output | 1 | Non-secure debug enable |
| s_dbg_en_o | output | 1 | Secure debug enable |
| bscan_en_o | output | 1 | Boundary scan enable |
| fail_o | output | 1 | Sticky failed-unlock flag |

## Verification
A key register that is corrupted or left writable in the closed state shows up at the enables. The next correct response then fails to unlock, which is visible two cycles after submission. Alternatively, a rejected word ends up unlocking the world. A wrong sequencer state shows up as `chal_vld_o` or `wipe_req_o` at the wrong cycle. It can also show up as an enable that rises without a preceding acknowledge, which the bench sees in the cycle right after the acknowledge. A crossed world index shows up as the wrong enable after the first grant.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
  typedef enum logic [1:0] {
    LVL_OFF   = 2'd0,
    LVL_NODBG = 2'd1,
    LVL_CHAL  = 2'd2,
    LVL_OPEN  = 2'd3
  } sec_level_e;

  typedef enum logic [1:0] {
    LC_OPEN   = 2'd0,
    LC_CLOSED = 2'd1,
    LC_NORET  = 2'd2,
    LC_CLOSE2 = 2'd3
  } lc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHAL,
    ST_CMP,
    ST_WIPE
  } unlock_st_e;

  localparam int unsigned NUM_WORLDS = 2;
  localparam int unsigned W_NS = 0;
  localparam int unsigned W_S  = 1;
endpackage

// File: rtl/dbg_key_store.sv
module dbg_key_store
  import dbg_gate_pkg::*;
#(
  parameter int unsigned KEY_W  = 128,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned NWORD = KEY_W / WORD_W,
  localparam int unsigned IDX_W = (NWORD > 1) ? $clog2(NWORD) : 1
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_i,
  input  logic                                lock_i,
  input  logic                                sel_i,
  input  logic [IDX_W-1:0]                    word_i,
  input  logic [WORD_W-1:0]                   data_i,
  output logic [NUM_WORLDS-1:0][KEY_W-1:0]    keys_o
);
  for (genvar w = 0; w < NUM_WORLDS; w++) begin : g_key
    logic [KEY_W-1:0] key_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        key_q <= '0;
      end else if (wr_i && !lock_i && (32'(sel_i) == w)) begin
        key_q[int'(word_i)*WORD_W +: WORD_W] <= data_i;
      end
    end
    assign keys_o[w] = key_q;
  end
endmodule

// File: rtl/dbg_resp_cmp.sv
module dbg_resp_cmp
  import dbg_gate_pkg::*;
#(
  parameter int unsigned KEY_W = 128
) (
  input  logic [KEY_W-1:0]                 resp_i,
  input  logic [NUM_WORLDS-1:0][KEY_W-1:0] keys_i,
  output logic [NUM_WORLDS-1:0]            match_o
);
  for (genvar w = 0; w < NUM_WORLDS; w++) begin : g_cmp
    assign match_o[w] = (resp_i == keys_i[w]);
  end
endmodule

// File: rtl/dbg_unlock_fsm.sv
module dbg_unlock_fsm
  import dbg_gate_pkg::*;
#(
  parameter int unsigned KEY_W = 128
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  active_i,
  input  logic                  req_i,
  input  logic                  resp_vld_i,
  input  logic [KEY_W-1:0]      resp_i,
  input  logic [NUM_WORLDS-1:0] match_i,
  input  logic                  wipe_ack_i,
  output logic [KEY_W-1:0]      resp_q_o,
  output logic                  chal_vld_o,
  output logic                  wipe_req_o,
  output logic [NUM_WORLDS-1:0] grant_o,
  output logic                  fail_o
);
  unlock_st_e st_q;
  logic [NUM_WORLDS-1:0] pend_q, grant_q;
  logic fail_q;
  logic [KEY_W-1:0] resp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      pend_q  <= '0;
      grant_q <= '0;
      fail_q  <= 1'b0;
      resp_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (active_i && req_i) begin
            st_q   <= ST_CHAL;
            fail_q <= 1'b0;
          end else if (active_i && resp_vld_i) begin
            fail_q <= 1'b1;  // response with no request
          end
        end
        ST_CHAL: begin
          if (!active_i) begin
            st_q <= ST_IDLE;
          end else if (resp_vld_i) begin
            resp_q <= resp_i;
            st_q   <= ST_CMP;
          end
        end
        ST_CMP: begin
          if (|match_i) begin
            pend_q <= match_i;
            st_q   <= ST_WIPE;
          end else begin
            fail_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        ST_WIPE: begin
          if (wipe_ack_i) begin
            grant_q <= grant_q | pend_q;
            st_q    <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign resp_q_o   = resp_q;
  assign chal_vld_o = (st_q == ST_CHAL);
  assign wipe_req_o = (st_q == ST_WIPE);
  assign grant_o    = grant_q;
  assign fail_o     = fail_q;
endmodule

// File: rtl/dbg_unlock_gate.sv
module dbg_unlock_gate
  import dbg_gate_pkg::*;
#(
  parameter int unsigned UID_W  = 64,
  parameter int unsigned KEY_W  = 128,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned NWORD = KEY_W / WORD_W,
  localparam int unsigned IDX_W = (NWORD > 1) ? $clog2(NWORD) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        sec_level_i,
  input  logic [1:0]        lifecycle_i,
  input  logic [UID_W-1:0]  uid_i,
  input  logic              key_wr_i,
  input  logic              key_sel_i,
  input  logic [IDX_W-1:0]  key_word_i,
  input  logic [WORD_W-1:0] key_data_i,
  input  logic              req_i,
  output logic [UID_W-1:0]  chal_o,
  output logic              chal_vld_o,
  input  logic              resp_vld_i,
  input  logic [KEY_W-1:0]  resp_i,
  output logic              wipe_req_o,
  input  logic              wipe_ack_i,
  output logic              ns_dbg_en_o,
  output logic              s_dbg_en_o,
  output logic              bscan_en_o,
  output logic              fail_o
);
  sec_level_e lvl;
  lc_e lc;
  logic lc_closed, lc_noret, active;
  logic [NUM_WORLDS-1:0][KEY_W-1:0] keys;
  logic [NUM_WORLDS-1:0] match, grant;
  logic [KEY_W-1:0] resp_q;

  assign lvl       = sec_level_e'(sec_level_i);
  assign lc        = lc_e'(lifecycle_i);
  assign lc_closed = (lc == LC_CLOSED) || (lc == LC_CLOSE2);
  assign lc_noret  = (lc == LC_NORET);
  assign active    = (lvl == LVL_CHAL) && lc_closed;

  dbg_key_store #(.KEY_W(KEY_W), .WORD_W(WORD_W)) u_keys (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (key_wr_i),
    .lock_i (lc != LC_OPEN),
    .sel_i  (key_sel_i),
    .word_i (key_word_i),
    .data_i (key_data_i),
    .keys_o (keys)
  );

  dbg_resp_cmp #(.KEY_W(KEY_W)) u_cmp (
    .resp_i  (resp_q),
    .keys_i  (keys),
    .match_o (match)
  );

  dbg_unlock_fsm #(.KEY_W(KEY_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .req_i      (req_i),
    .resp_vld_i (resp_vld_i),
    .resp_i     (resp_i),
    .match_i    (match),
    .wipe_ack_i (wipe_ack_i),
    .resp_q_o   (resp_q),
    .chal_vld_o (chal_vld_o),
    .wipe_req_o (wipe_req_o),
    .grant_o    (grant),
    .fail_o     (fail_o)
  );

  assign chal_o = chal_vld_o ? uid_i : '0;

  always_comb begin
    ns_dbg_en_o = 1'b0;
    s_dbg_en_o  = 1'b0;
    if (!lc_noret) begin
      unique case (lvl)
        LVL_OPEN: begin
          ns_dbg_en_o = 1'b1;
          s_dbg_en_o  = 1'b1;
        end
        LVL_CHAL: begin
          if (lc == LC_OPEN) begin
            ns_dbg_en_o = 1'b1;
          end else begin
            ns_dbg_en_o = grant[W_NS];
            s_dbg_en_o  = grant[W_S];
          end
        end
        default: ;
      endcase
    end
  end

  assign bscan_en_o = (lvl != LVL_OFF) && !lc_noret;
endmodule

// File: rtl/dbg_unlock_gate_chk.sv
module dbg_unlock_gate_chk #(
  parameter int unsigned UID_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       sec_level_i,
  input logic [1:0]       lifecycle_i,
  input logic [UID_W-1:0] uid_i,
  input logic [UID_W-1:0] chal_o,
  input logic             chal_vld_o,
  input logic             wipe_req_o,
  input logic             wipe_ack_i,
  input logic             ns_dbg_en_o,
  input logic             s_dbg_en_o,
  input logic             bscan_en_o
);
  logic cl_now, cl_prev, ns_prev, s_prev, ackd_prev;
  assign cl_now = (sec_level_i == 2'd2) && (lifecycle_i == 2'd1 || lifecycle_i == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cl_prev   <= 1'b0;
      ns_prev   <= 1'b0;
      s_prev    <= 1'b0;
      ackd_prev <= 1'b0;
    end else begin
      cl_prev   <= cl_now;
      ns_prev   <= ns_dbg_en_o;
      s_prev    <= s_dbg_en_o;
      ackd_prev <= wipe_req_o && wipe_ack_i;
    end
  end

  // R3
  chal_is_uid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chal_vld_o |-> (chal_o == uid_i));

  // R7
  wipe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wipe_req_o && !wipe_ack_i) |=> wipe_req_o);

  // R7
  ns_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl_now && cl_prev && ns_dbg_en_o && !ns_prev) |-> ackd_prev);

  // R7
  s_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl_now && cl_prev && s_dbg_en_o && !s_prev) |-> ackd_prev);

  // R8
  grant_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl_now && cl_prev && (ns_prev || s_prev)) |-> ((ns_dbg_en_o || !ns_prev) && (s_dbg_en_o || !s_prev)));

  // R1 R11
  off_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_level_i == 2'd0) |-> (!ns_dbg_en_o && !s_dbg_en_o && !bscan_en_o));
endmodule

bind dbg_unlock_gate dbg_unlock_gate_chk #(.UID_W(UID_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sec_level_i (sec_level_i),
  .lifecycle_i (lifecycle_i),
  .uid_i       (uid_i),
  .chal_o      (chal_o),
  .chal_vld_o  (chal_vld_o),
  .wipe_req_o  (wipe_req_o),
  .wipe_ack_i  (wipe_ack_i),
  .ns_dbg_en_o (ns_dbg_en_o),
  .s_dbg_en_o  (s_dbg_en_o),
  .bscan_en_o  (bscan_en_o)
);

// File: tb/tb_dbg_unlock_gate.sv
`timescale 1ns/1ps
module tb_dbg_unlock_gate;
  localparam logic [63:0]  UID  = 64'h5a3c_e1f0_0918_7b26;
  localparam logic [127:0] NKEY = 128'h1f2e_3d4c_5b6a_7988_0102_0304_a5a5_5a5a;
  localparam logic [127:0] SKEY = 128'h9988_7766_5544_3322_fedc_ba98_0f0f_f0f0;
  localparam logic [127:0] BAD  = 128'h0000_1111_2222_3333_4444_5555_6666_7777;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [1:0] sec_level = 2'd2, lifecycle = 2'd1;
  logic key_wr = 1'b0, key_sel = 1'b0;
  logic [1:0] key_word = '0;
  logic [31:0] key_data = '0;
  logic req = 1'b0, resp_vld = 1'b0, wipe_ack = 1'b0;
  logic [127:0] resp = '0;
  logic [63:0] chal;
  logic chal_vld, wipe_req, ns_en, s_en, bs_en, fail;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbg_unlock_gate dut (
    .clk_i(clk), .rst_ni(rst_ni), .sec_level_i(sec_level), .lifecycle_i(lifecycle),
    .uid_i(UID), .key_wr_i(key_wr), .key_sel_i(key_sel), .key_word_i(key_word),
    .key_data_i(key_data), .req_i(req), .chal_o(chal), .chal_vld_o(chal_vld),
    .resp_vld_i(resp_vld), .resp_i(resp), .wipe_req_o(wipe_req), .wipe_ack_i(wipe_ack),
    .ns_dbg_en_o(ns_en), .s_dbg_en_o(s_en), .bscan_en_o(bs_en), .fail_o(fail)
  );

  typedef struct {
    string tag;
    logic [5:0] flags;  // ns s bs wipe fail chv
    logic [63:0] chal;
  } exp_t;
  exp_t q[$];

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic expect_st(string tag, bit n, bit s, bit b, bit w, bit f, bit c);
    exp_t e;
    e.tag = tag;
    e.flags = {n, s, b, w, f, c};
    e.chal = c ? UID : 64'h0;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        exp_t e;
        logic [5:0] act;
        e = q.pop_front();
        act = {ns_en, s_en, bs_en, wipe_req, fail, chal_vld};
        checks++;
        if (act !== e.flags || chal !== e.chal) begin
          errors++;
          $display("FAIL %s: act ns/s/bs/wipe/fail/chv=%b chal=%h exp %b chal=%h",
                   e.tag, act, chal, e.flags, e.chal);
        end
      end
    end
  end

  task automatic write_key(bit sel, logic [127:0] k);
    for (int w = 0; w < 4; w++) begin
      key_wr = 1'b1; key_sel = sel; key_word = 2'(w); key_data = k[w*32 +: 32];
      cyc();
    end
    key_wr = 1'b0;
  endtask

  task automatic do_req();
    req = 1'b1; cyc(); req = 1'b0;
  endtask

  task automatic do_resp(logic [127:0] r);
    resp_vld = 1'b1; resp = r; cyc(); resp_vld = 1'b0;
  endtask

  task automatic do_ack();
    wipe_ack = 1'b1; cyc(); wipe_ack = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    cyc();
    expect_st("R3 reset idle", 0, 0, 1, 0, 0, 0);

    sec_level = 2'd3; cyc(); expect_st("R1 level open", 1, 1, 1, 0, 0, 0);
    sec_level = 2'd1; cyc(); expect_st("R1 level nodebug", 0, 0, 1, 0, 0, 0);
    sec_level = 2'd0; cyc(); expect_st("R1 R11 level off", 0, 0, 0, 0, 0, 0);
    sec_level = 2'd2; lifecycle = 2'd0; cyc();
    expect_st("R2 lifecycle open", 1, 0, 1, 0, 0, 0);
    do_req(); expect_st("R3 request ignored when open", 1, 0, 1, 0, 0, 0);

    write_key(1'b0, NKEY);
    write_key(1'b1, SKEY);
    lifecycle = 2'd1;
    key_wr = 1'b1; key_sel = 1'b0; key_word = 2'd0; key_data = 32'hdead_beef;
    cyc(); key_wr = 1'b0;
    expect_st("R9 closed, nothing granted", 0, 0, 1, 0, 0, 0);

    do_resp(NKEY); expect_st("R6 response without request", 0, 0, 1, 0, 1, 0);
    do_req(); expect_st("R3 R5 challenge shown, fail cleared", 0, 0, 1, 0, 0, 1);
    do_resp(BAD); expect_st("R4 compare cycle", 0, 0, 1, 0, 0, 0);
    cyc(); expect_st("R5 mismatch fails", 0, 0, 1, 0, 1, 0);

    do_req(); expect_st("R3 second challenge", 0, 0, 1, 0, 0, 1);
    do_resp(NKEY); expect_st("R7 compare, no wipe yet", 0, 0, 1, 0, 0, 0);
    cyc(); expect_st("R7 wipe raised", 0, 0, 1, 1, 0, 0);
    cyc(); cyc(); expect_st("R7 wipe held without ack", 0, 0, 1, 1, 0, 0);
    do_ack(); expect_st("R4 R9 normal world granted", 1, 0, 1, 0, 0, 0);

    do_req(); do_resp(SKEY); cyc();
    expect_st("R7 wipe for secure world", 1, 0, 1, 1, 0, 0);
    do_ack(); expect_st("R4 both worlds granted", 1, 1, 1, 0, 0, 0);

    do_req(); do_resp(BAD); cyc();
    expect_st("R8 grants survive failure", 1, 1, 1, 0, 1, 0);

    lifecycle = 2'd2; cyc(); expect_st("R11 R1 no-return", 0, 0, 0, 0, 1, 0);
    sec_level = 2'd3; cyc(); expect_st("R1 no-return overrides open", 0, 0, 0, 0, 1, 0);

    @(negedge clk) rst_ni = 1'b0;
    @(negedge clk) rst_ni = 1'b1; sec_level = 2'd2; lifecycle = 2'd3;
    cyc(); expect_st("R8 reset clears grants", 0, 0, 1, 0, 0, 0);
    do_req(); do_resp(128'h0); cyc();
    expect_st("R10 zero response matches", 0, 0, 1, 1, 0, 0);
    do_ack(); expect_st("R10 both worlds from zero keys", 1, 1, 1, 0, 0, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule